// File: doc/BRIEF.md
# Serial Flash Sleep and Signature Command Handler

This block is the device-side command logic that puts a serial flash device into a low-power sleep state and brings it out again. It watches the chip-select, serial clock and serial data-in pins. It decodes the first byte of each transaction as an opcode, counts the whole bytes that follow, and acts when chip-select returns high. The pins are oversampled by the system clock. Chip-select is active low.

While the device sleeps, one opcode is still honoured. Sent alone, that opcode wakes the device. Sent with three dummy bytes after it, the opcode makes the block shift a fixed signature byte out on data-out for as long as chip-select stays low. Each of the two uses has its own wake-up delay. The entry delay and both wake-up delays are counted in system clock cycles, and ready stays low while any of them is running. A busy flag from the rest of the device blocks the wake and signature opcode, so an operation in progress is left alone.

Top module: `spi_pd_ctrl`

## Requirements
- R1: After reset, sleep_o is 0, ready_o is 1 and sdo_oe_o is 0.
- R2: Opcode 0xB9 with exactly 8 bits before chip-select rises takes ready_o low for TDP system cycles. After that, sleep_o is 1 and ready_o is 1.
- R3: An 0xB9 transaction that is longer than one byte leaves the device awake. An 0xB9 transaction that is cut off mid-byte also leaves the device awake.
- R4: While asleep, any opcode other than 0xAB leaves sleep_o at 1 and sdo_oe_o at 0, including when dummy bytes follow it.
- R5: While asleep, 0xAB followed at once by chip-select rising takes ready_o low for TRES1 cycles. Then sleep_o goes to 0 and ready_o goes to 1.
- R6: Opcode 0xAB followed by three dummy bytes makes the block drive the SIG parameter on sdo_o, most significant bit first, with sdo_oe_o at 1. The bits change on falling serial clock edges and the byte repeats while chip-select stays low. This works both awake and asleep.
- R7: Once a signature read ends with chip-select high, ready_o is low for TRES2 cycles. After that, sleep_o is 0 and ready_o is 1.
- R8: When busy_i is 1 as the 0xAB opcode completes, the command is ignored. No signature is driven and the sleep state does not change.
- R9: If chip-select rises when the bit count is not a whole number of bytes, the command is aborted and the state is unchanged.
- R10: A transaction whose chip-select falls while ready_o is 0 is ignored.
- R11: Serial clock modes 0 and 3 both work. Data-in is sampled on rising edges, most significant bit first.
- R12: sdo_oe_o is 0 whenever chip-select is high or no signature phase is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip-select, active low |
| sck_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| busy_i | input | 1 | Erase, program or status write in progress |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Data-out enable; the pad is high-impedance when 0 |
| sleep_o | output | 1 | Device is in the sleep state |
| ready_o | output | 1 | Commands are accepted |

## Verification
The bench builds the block with TDP=100, TRES1=200, TRES2=400 and SIG=8'hA6. Because the three delays are far apart, one sample taken 240 cycles after chip-select rises tells a bare release, which is done by then, from a signature release, which is still counting. A sample taken early in each countdown shows ready low with the old sleep state still held. The signature 8'hA6 is neither a palindrome nor all ones or all zeros, so a bit-order error or a stuck output changes the captured bytes.

// File: rtl/spi_pd_pkg.sv
package spi_pd_pkg;
  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;
  localparam int unsigned DUMMY_BYTES = 3;

  typedef enum logic [1:0] {
    ST_AWAKE = 2'd0,
    ST_ENTER = 2'd1,
    ST_SLEEP = 2'd2,
    ST_WAKE  = 2'd3
  } pd_state_e;
endpackage

// File: rtl/spi_pd_sync.sv
module spi_pd_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    logic              last_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe_q <= {STAGES{RST_VAL[b]}};
        last_q <= RST_VAL[b];
      end else begin
        pipe_q <= {pipe_q[STAGES-2:0], d_i[b]};
        last_q <= pipe_q[STAGES-1];
      end
    end
    assign q_o[b]    = pipe_q[STAGES-1];
    assign rise_o[b] = pipe_q[STAGES-1] & ~last_q;
    assign fall_o[b] = ~pipe_q[STAGES-1] & last_q;
  end
endmodule

// File: rtl/spi_pd_shift.sv
module spi_pd_shift #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned CNT_W  = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cs_s_i,
  input  logic                      sck_rise_i,
  input  logic                      sdi_s_i,
  output logic                      byte_done_o,
  output logic [BYTE_W-1:0]         byte_val_o,
  output logic [CNT_W-1:0]          byte_idx_o,
  output logic [$clog2(BYTE_W)-1:0] bit_cnt_o
);
  localparam int unsigned BW = $clog2(BYTE_W);
  localparam logic [BW-1:0]    BIT_LAST = BW'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] IDX_MAX  = '1;

  logic [BYTE_W-2:0] sh_q;
  logic [BW-1:0]     bit_q;
  logic [CNT_W-1:0]  idx_q;

  assign byte_done_o = sck_rise_i && !cs_s_i && (bit_q == BIT_LAST);
  assign byte_val_o  = {sh_q, sdi_s_i};
  assign byte_idx_o  = idx_q;
  assign bit_cnt_o   = bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= '0;
      idx_q <= '0;
    end else if (cs_s_i) begin
      bit_q <= '0;
      idx_q <= '0;
    end else if (sck_rise_i) begin
      sh_q  <= {sh_q[BYTE_W-3:0], sdi_s_i};
      bit_q <= bit_q + 1'b1;
      if (bit_q == BIT_LAST && idx_q != IDX_MAX) idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/spi_pd_seq.sv
module spi_pd_seq
  import spi_pd_pkg::*;
#(
  parameter int unsigned TDP   = 100,
  parameter int unsigned TRES1 = 200,
  parameter int unsigned TRES2 = 400,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned BIT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_s_i,
  input  logic             cs_rise_i,
  input  logic             cs_fall_i,
  input  logic             busy_i,
  input  logic             byte_done_i,
  input  logic [7:0]       byte_val_i,
  input  logic [CNT_W-1:0] byte_idx_i,
  input  logic [BIT_W-1:0] bit_cnt_i,
  output logic             out_en_o,
  output logic             sleep_o,
  output logic             ready_o
);
  localparam int unsigned T12  = (TDP > TRES1) ? TDP : TRES1;
  localparam int unsigned TMAX = (T12 > TRES2) ? T12 : TRES2;
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam logic [CNT_W-1:0] IDX_SIG = CNT_W'(DUMMY_BYTES + 1);

  pd_state_e     state_q;
  logic [TW-1:0] cnt_q;
  logic          sleep_q, cmd_ok_q, ab_ok_q, out_q;
  logic [7:0]    op_q;
  logic          whole;

  assign ready_o  = (state_q == ST_AWAKE) || (state_q == ST_SLEEP);
  assign sleep_o  = sleep_q;
  assign out_en_o = out_q;
  assign whole    = (bit_cnt_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_AWAKE;
      cnt_q    <= '0;
      sleep_q  <= 1'b0;
      cmd_ok_q <= 1'b0;
      ab_ok_q  <= 1'b0;
      out_q    <= 1'b0;
      op_q     <= '0;
    end else begin
      if (cs_fall_i) cmd_ok_q <= ready_o;
      if (byte_done_i && byte_idx_i == '0) begin
        op_q    <= byte_val_i;
        ab_ok_q <= cmd_ok_q && (byte_val_i == OP_WAKE) && !busy_i;
      end
      if (cs_s_i) out_q <= 1'b0;
      else if (byte_done_i && ab_ok_q && byte_idx_i == CNT_W'(DUMMY_BYTES)) out_q <= 1'b1;

      unique case (state_q)
        ST_AWAKE: begin
          if (cs_rise_i && cmd_ok_q && whole) begin
            if (op_q == OP_SLEEP && byte_idx_i == CNT_W'(1)) begin
              state_q <= ST_ENTER;
              cnt_q   <= TW'(TDP);
            end else if (ab_ok_q && byte_idx_i >= IDX_SIG) begin
              state_q <= ST_WAKE;
              cnt_q   <= TW'(TRES2);
            end
          end
        end
        ST_SLEEP: begin
          if (cs_rise_i && cmd_ok_q && whole && ab_ok_q) begin
            if (byte_idx_i == CNT_W'(1)) begin
              state_q <= ST_WAKE;
              cnt_q   <= TW'(TRES1);
            end else if (byte_idx_i >= IDX_SIG) begin
              state_q <= ST_WAKE;
              cnt_q   <= TW'(TRES2);
            end
          end
        end
        ST_ENTER: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q <= TW'(1)) begin
            state_q <= ST_SLEEP;
            sleep_q <= 1'b1;
          end
        end
        default: begin
          cnt_q <= cnt_q - 1'b1;
          if (cnt_q <= TW'(1)) begin
            state_q <= ST_AWAKE;
            sleep_q <= 1'b0;
          end
        end
      endcase
    end
  end

  // R10
  ready_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> cnt_q != '0);

  // R9
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && !whole && ready_o) |=> $stable(state_q));

  // R8
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done_i && byte_idx_i == '0 && busy_i) |=> !ab_ok_q);

  // R5
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_q) |-> (ready_o && state_q == ST_AWAKE));
endmodule

// File: rtl/spi_pd_sdo.sv
module spi_pd_sdo #(
  parameter int unsigned SIG_W = 8,
  parameter logic [SIG_W-1:0] SIG = 8'h5C
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_s_i,
  input  logic sck_fall_i,
  input  logic out_en_i,
  output logic sdo_o,
  output logic oe_o
);
  localparam int unsigned PW = $clog2(SIG_W);
  localparam logic [PW-1:0] PTR_LAST = PW'(SIG_W - 1);

  logic [PW-1:0] ptr_q;
  logic          sdo_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (cs_s_i) begin
      ptr_q <= '0;
      oe_q  <= 1'b0;
    end else if (sck_fall_i && out_en_i) begin
      sdo_q <= SIG[PTR_LAST - ptr_q];
      ptr_q <= (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;
      oe_q  <= 1'b1;
    end
  end

  assign sdo_o = sdo_q;
  assign oe_o  = oe_q && !cs_s_i;

  // R6
  oe_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oe_o) |-> $past(sck_fall_i && out_en_i));

  // R12
  oe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_o && !$past(oe_o)) |-> $past(!cs_s_i));
endmodule

// File: rtl/spi_pd_ctrl.sv
module spi_pd_ctrl #(
  parameter int unsigned TDP   = 100,
  parameter int unsigned TRES1 = 200,
  parameter int unsigned TRES2 = 400,
  parameter logic [7:0]  SIG   = 8'h5C,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic sdi_i,
  input  logic busy_i,
  output logic sdo_o,
  output logic sdo_oe_o,
  output logic sleep_o,
  output logic ready_o
);
  localparam int unsigned CNT_W = 3;
  localparam int unsigned BIT_W = 3;

  logic [2:0] pin_s, pin_rise, pin_fall;
  logic cs_s, sck_rise, sck_fall, sdi_s, cs_rise, cs_fall;
  logic byte_done, out_en;
  logic [7:0] byte_val;
  logic [CNT_W-1:0] byte_idx;
  logic [BIT_W-1:0] bit_cnt;

  spi_pd_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({sdi_i, sck_i, cs_ni}),
    .q_o(pin_s), .rise_o(pin_rise), .fall_o(pin_fall));

  assign cs_s     = pin_s[0];
  assign cs_rise  = pin_rise[0];
  assign cs_fall  = pin_fall[0];
  assign sck_rise = pin_rise[1];
  assign sck_fall = pin_fall[1];
  assign sdi_s    = pin_s[2];

  spi_pd_shift #(.BYTE_W(8), .CNT_W(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_s_i(cs_s), .sck_rise_i(sck_rise),
    .sdi_s_i(sdi_s), .byte_done_o(byte_done), .byte_val_o(byte_val),
    .byte_idx_o(byte_idx), .bit_cnt_o(bit_cnt));

  spi_pd_seq #(.TDP(TDP), .TRES1(TRES1), .TRES2(TRES2),
               .CNT_W(CNT_W), .BIT_W(BIT_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_s_i(cs_s), .cs_rise_i(cs_rise),
    .cs_fall_i(cs_fall), .busy_i(busy_i), .byte_done_i(byte_done),
    .byte_val_i(byte_val), .byte_idx_i(byte_idx), .bit_cnt_i(bit_cnt),
    .out_en_o(out_en), .sleep_o(sleep_o), .ready_o(ready_o));

  spi_pd_sdo #(.SIG_W(8), .SIG(SIG)) u_sdo (
    .clk_i(clk_i), .rst_ni(rst_ni), .cs_s_i(cs_s), .sck_fall_i(sck_fall),
    .out_en_i(out_en), .sdo_o(sdo_o), .oe_o(sdo_oe_o));

  // R12
  oe_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s && $past(cs_s)) |-> !sdo_oe_o);
endmodule

// File: tb/spi_pd_ctrl_bench.sv
module spi_pd_ctrl_bench;
  localparam int unsigned TDP = 100, TRES1 = 200, TRES2 = 400;
  localparam logic [7:0] SIG = 8'hA6;
  localparam int H = 8;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, sdi = 0, busy = 0;
  logic sdo, sdo_oe, sleep, ready;
  int total = 0, bad = 0;
  logic [63:0] rx;
  bit oe_any;

  always #5 clk = ~clk;

  spi_pd_ctrl #(.TDP(TDP), .TRES1(TRES1), .TRES2(TRES2), .SIG(SIG)) u_spi_pd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .busy_i(busy), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .sleep_o(sleep), .ready_o(ready));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // tx is left-aligned; returns sampled data-out bits left-aligned
  task automatic xfer(input logic [63:0] tx, input int nbits, input bit m3);
    rx = '0;
    oe_any = 0;
    @(negedge clk);
    sck = m3;
    wait_cyc(H);
    cs_n = 0;
    wait_cyc(H);
    for (int i = 0; i < nbits; i++) begin
      sck = 0;
      sdi = tx[63-i];
      wait_cyc(H);
      rx[63-i] = sdo;
      if (sdo_oe) oe_any = 1;
      sck = 1;
      wait_cyc(H);
    end
    if (!m3) sck = 0;
    wait_cyc(H);
    cs_n = 1;
    wait_cyc(2*H);
  endtask

  task automatic go_sleep();
    xfer({8'hB9, 56'h0}, 8, 0);
    wait_cyc(TDP + 40);
  endtask

  task automatic t_reset();
    check("R1 sleep", sleep, 0);
    check("R1 ready", ready, 1);
    check("R1 oe", sdo_oe, 0);
  endtask

  task automatic t_sig_awake();
    xfer({8'hAB, 24'h0, 32'h0}, 48, 0);
    check("R6 sig awake", rx[31:16], {SIG, SIG});
    check("R12 oe seen", oe_any, 1);
    check("R12 oe after cs", sdo_oe, 0);
    check("R7 ready low", ready, 0);
    wait_cyc(TRES2 + 20);
    check("R7 ready back", ready, 1);
    check("R7 awake", sleep, 0);
  endtask

  task automatic t_enter();
    xfer({8'hB9, 56'h0}, 8, 0);
    wait_cyc(30);
    check("R2 ready low", ready, 0);
    check("R2 not yet asleep", sleep, 0);
    wait_cyc(TDP);
    check("R2 asleep", sleep, 1);
    check("R2 ready", ready, 1);
  endtask

  task automatic t_filter();
    xfer({8'h9F, 24'h0, 32'h0}, 48, 0);
    check("R4 no output", oe_any, 0);
    check("R4 still asleep", sleep, 1);
    xfer({8'h03, 56'h0}, 8, 0);
    wait_cyc(TRES1 + 20);
    check("R4 bare opcode", sleep, 1);
  endtask

  task automatic t_busy();
    busy = 1;
    xfer({8'hAB, 56'h0}, 8, 0);
    wait_cyc(TRES1 + 20);
    check("R8 bare busy", sleep, 1);
    xfer({8'hAB, 24'h0, 32'h0}, 48, 0);
    check("R8 no sig", oe_any, 0);
    wait_cyc(TRES2 + 20);
    check("R8 sig busy", sleep, 1);
    busy = 0;
  endtask

  task automatic t_abort();
    xfer({8'hAB, 56'h0}, 11, 0);
    wait_cyc(TRES1 + 20);
    check("R9 abort asleep", sleep, 1);
    check("R9 abort ready", ready, 1);
  endtask

  task automatic t_release();
    xfer({8'hAB, 56'h0}, 8, 0);
    wait_cyc(30);
    check("R5 ready low", ready, 0);
    check("R5 still asleep", sleep, 1);
    wait_cyc(TRES1 - 30 + 20);
    check("R5 awake", sleep, 0);
    check("R5 ready", ready, 1);
  endtask

  task automatic t_b9_len();
    xfer({8'hB9, 56'h0}, 12, 0);
    wait_cyc(TDP + 40);
    check("R3 partial", sleep, 0);
    xfer({8'hB9, 8'h00, 48'h0}, 16, 0);
    wait_cyc(TDP + 40);
    check("R3 long", sleep, 0);
  endtask

  task automatic t_mode3();
    xfer({8'hB9, 56'h0}, 8, 1);
    wait_cyc(TDP + 40);
    check("R11 mode3 asleep", sleep, 1);
    xfer({8'hAB, 24'h0, 32'h0}, 56, 1);
    check("R11 R6 mode3 sig", rx[31:8], {SIG, SIG, SIG});
    wait_cyc(TRES1 + 20);
    check("R7 still low", ready, 0);
    check("R7 still asleep", sleep, 1);
    wait_cyc(TRES2 - TRES1);
    check("R7 awake", sleep, 0);
    check("R7 ready", ready, 1);
  endtask

  task automatic t_during_wait();
    xfer({8'hB9, 56'h0}, 8, 0);
    xfer({8'hAB, 56'h0}, 8, 0);
    wait_cyc(TDP + TRES1);
    check("R10 asleep", sleep, 1);
    t_release();
  endtask

  initial begin
    wait_cyc(2);
    t_reset();
    rst_n = 1;
    wait_cyc(4);
    t_reset();
    t_sig_awake();
    t_enter();
    t_filter();
    t_busy();
    t_abort();
    t_release();
    t_b9_len();
    go_sleep();
    check("R2 resleep", sleep, 1);
    t_release();
    t_mode3();
    t_during_wait();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule